// File: doc/BRIEF.md
# Multi-Link Readout Request Sequencer

This block gathers one event from several front-end modules at once. It walks a nested index of front-end card, readout chip and channel. At each position it sends one readout request word, in lockstep, to every link that an external position table enables. It then waits until that request has been answered before it moves to the next position. The walk is started by a one-cycle start pulse and can be cut short at any time by an abort.

Before each request the block checks that every receive FIFO reports enough free space. If any FIFO is short, sending stalls until all of them have room. A pending request is finished in one of two ways: every enabled link has signalled that its response is complete, or a programmable cycle budget runs out. In the second case a sticky per-link flag records which links did not answer. Table positions whose mask is empty are passed over without a request. The table itself sits outside the block: the block presents a linear position address and reads back a mask in the same cycle.

Top module: `link_sweep_sequencer`

## Requirements
- R1: After reset, busy_o, done_o, req_valid_o, tmo_flag_o and lut_addr_o are all zero.
- R2: A start pulse while idle raises busy_o in the next cycle. A start pulse while busy has no effect on the sequence of requests.
- R3: Positions are visited with channel innermost, then chip, then card. lut_addr_o equals (card*N_CHIPS + chip)*N_CHANS + chan.
- R4: req_word_o is {zs, card, chip, chan}, with chan in the least significant bits and each index ceil(log2(count)) bits wide (at least 1). zs is the value of zs_mode_i sampled with the accepted start pulse.
- R5: Each request appears as a one-cycle pulse on req_valid_o equal to lut_mask_i for that position. A position with an all-zero mask produces no request and costs exactly one cycle.
- R6: A request is issued only in a cycle where every link's fifo_free_i field is at least FREE_MIN (default 2048). Otherwise the block holds at that position.
- R7: A pending request completes when every enabled link has pulsed resp_done_i. If the last response is sampled d cycles after the request pulse, the next request pulse follows d+2 cycles after the previous one, plus one cycle per skipped empty position.
- R8: The wait budget is loaded from tmo_limit_i (L) at each request. An unfinished request is abandoned after L+1 waiting cycles, so the next pulse follows L+2 cycles later. A response arriving in the final waiting cycle counts as completion.
- R9: On expiry, tmo_flag_o bit k is set for every enabled link k that had not responded. The flags stay set until the next accepted start, which clears them.
- R10: After the last position finishes, done_o pulses for exactly one cycle, and busy_o is low in that same cycle.
- R11: Abort while busy makes busy_o low in the next cycle, with no done_o and no further requests. The next start begins again at position 0.
- R12: busy_o stays high from the cycle after start until done_o or abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an event sweep (pulse) |
| abort_i | input | 1 | Stop the current sweep at once |
| zs_mode_i | input | 1 | Zero-suppression flag placed in request words |
| tmo_limit_i | input | TMO_W | Wait budget in cycles, loaded per request |
| fifo_free_i | input | N_LINKS*FREE_W | Per-link receive FIFO free space |
| resp_done_i | input | N_LINKS | Per-link response-complete pulse |
| lut_addr_o | output | POS_W | Linear position into the external mask table |
| lut_mask_i | input | N_LINKS | Link-enable mask read from the table |
| req_valid_o | output | N_LINKS | Per-link request strobe |
| req_word_o | output | REQ_W | Request word shared by all links |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle end-of-sweep pulse |
| tmo_flag_o | output | N_LINKS | Sticky per-link timeout flags |

## Verification
The response-complete path and the timeout path can both act in the same waiting cycle. The bench provokes this by running a whole sweep with a response delay equal to the wait budget, so that the last response lands exactly in the cycle where the budget reaches zero. It expects completion to win: no timeout flag, and a request spacing of budget plus two cycles. Neighbouring sweeps, one with a delay one cycle longer and one with a link that never answers, show the expiry side of the same boundary. Their flags and request spacing are worked out from the table masks.

// File: rtl/lss_pkg.sv
package lss_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_LOOK = 2'd1,
      SEQ_WAIT = 2'd2
   } seq_state_t;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/lss_wrap_ctr.sv
module lss_wrap_ctr #(
   parameter int unsigned LIMIT = 4,
   parameter int unsigned W     = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o,
   output logic         at_max_o
);

   logic [W-1:0] cnt_q;

   assign at_max_o = (cnt_q == W'(LIMIT - 1));
   assign cnt_o    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (inc_i) begin
         cnt_q <= at_max_o ? '0 : cnt_q + W'(1);
      end
   end

endmodule

// File: rtl/lss_pos_counter.sv
module lss_pos_counter #(
   parameter int unsigned N_CARDS = 6,
   parameter int unsigned N_CHIPS = 4,
   parameter int unsigned N_CHANS = 79,
   parameter int unsigned CARD_W  = 3,
   parameter int unsigned CHIP_W  = 2,
   parameter int unsigned CHAN_W  = 7,
   parameter int unsigned POS_W   = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              adv_i,
   output logic [CARD_W-1:0] card_o,
   output logic [CHIP_W-1:0] chip_o,
   output logic [CHAN_W-1:0] chan_o,
   output logic [POS_W-1:0]  pos_o,
   output logic              last_o
);

   logic chan_max, chip_max, card_max;
   logic chip_inc, card_inc;
   logic [POS_W-1:0] pos_q;

   // channel is the fastest digit, card the slowest
   assign chip_inc = adv_i & chan_max;
   assign card_inc = chip_inc & chip_max;

   lss_wrap_ctr #(.LIMIT(N_CHANS), .W(CHAN_W)) chan_ctr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (clr_i),
      .inc_i    (adv_i),
      .cnt_o    (chan_o),
      .at_max_o (chan_max)
   );

   lss_wrap_ctr #(.LIMIT(N_CHIPS), .W(CHIP_W)) chip_ctr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (clr_i),
      .inc_i    (chip_inc),
      .cnt_o    (chip_o),
      .at_max_o (chip_max)
   );

   lss_wrap_ctr #(.LIMIT(N_CARDS), .W(CARD_W)) card_ctr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (clr_i),
      .inc_i    (card_inc),
      .cnt_o    (card_o),
      .at_max_o (card_max)
   );

   // linear table address kept alongside the digits to avoid a multiplier
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (clr_i) begin
         pos_q <= '0;
      end else if (adv_i) begin
         pos_q <= pos_q + POS_W'(1);
      end
   end

   assign pos_o  = pos_q;
   assign last_o = chan_max & chip_max & card_max;

endmodule

// File: rtl/lss_space_gate.sv
module lss_space_gate #(
   parameter int unsigned N_LINKS  = 4,
   parameter int unsigned FREE_W   = 16,
   parameter int unsigned FREE_MIN = 2048
) (
   input  logic [N_LINKS*FREE_W-1:0] fifo_free_i,
   output logic                      all_room_o
);

   logic [N_LINKS-1:0] link_ok;

   generate
      if (FREE_MIN == 0) begin : g_no_gate
         // a zero threshold removes the comparators entirely
         assign link_ok = '1;
         logic unused_free;
         assign unused_free = ^fifo_free_i;
      end else begin : g_gate
         for (genvar l = 0; l < N_LINKS; l++) begin : g_link
            assign link_ok[l] = (fifo_free_i[l*FREE_W +: FREE_W] >= FREE_W'(FREE_MIN));
         end
      end
   endgenerate

   assign all_room_o = &link_ok;

endmodule

// File: rtl/lss_wait_tracker.sv
module lss_wait_tracker #(
   parameter int unsigned N_LINKS = 4,
   parameter int unsigned TMO_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_i,
   input  logic               flag_clr_i,
   input  logic               load_i,
   input  logic [N_LINKS-1:0] mask_i,
   input  logic [TMO_W-1:0]   tmo_limit_i,
   input  logic               active_i,
   input  logic [N_LINKS-1:0] resp_done_i,
   output logic               complete_o,
   output logic               expire_o,
   output logic [N_LINKS-1:0] tmo_flag_o
);

   logic [N_LINKS-1:0] pending_q;
   logic [N_LINKS-1:0] left;
   logic [N_LINKS-1:0] flag_q;
   logic [TMO_W-1:0]   timer_q;

   assign left       = pending_q & ~resp_done_i;
   // completion is tested first, so a response in the last budget cycle wins
   assign complete_o = active_i & (left == '0);
   assign expire_o   = active_i & (left != '0) & (timer_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_q <= '0;
         timer_q   <= '0;
      end else if (clr_i) begin
         pending_q <= '0;
         timer_q   <= '0;
      end else if (load_i) begin
         pending_q <= mask_i;
         timer_q   <= tmo_limit_i;
      end else if (active_i) begin
         pending_q <= left;
         if (timer_q != '0) begin
            timer_q <= timer_q - TMO_W'(1);
         end
      end
   end

   generate
      for (genvar l = 0; l < N_LINKS; l++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flag_q[l] <= 1'b0;
            end else if (flag_clr_i) begin
               flag_q[l] <= 1'b0;
            end else if (expire_o && left[l]) begin
               flag_q[l] <= 1'b1;
            end
         end
      end
   endgenerate

   assign tmo_flag_o = flag_q;

endmodule

// File: rtl/link_sweep_sequencer.sv
module link_sweep_sequencer
   import lss_pkg::*;
#(
   parameter int unsigned N_LINKS  = 4,
   parameter int unsigned N_CARDS  = 6,
   parameter int unsigned N_CHIPS  = 4,
   parameter int unsigned N_CHANS  = 79,
   parameter int unsigned FREE_W   = 16,
   parameter int unsigned FREE_MIN = 2048,
   parameter int unsigned TMO_W    = 16,
   localparam int unsigned CARD_W  = idx_width(N_CARDS),
   localparam int unsigned CHIP_W  = idx_width(N_CHIPS),
   localparam int unsigned CHAN_W  = idx_width(N_CHANS),
   localparam int unsigned N_POS   = N_CARDS * N_CHIPS * N_CHANS,
   localparam int unsigned POS_W   = idx_width(N_POS),
   localparam int unsigned REQ_W   = 1 + CARD_W + CHIP_W + CHAN_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic                      abort_i,
   input  logic                      zs_mode_i,
   input  logic [TMO_W-1:0]          tmo_limit_i,
   input  logic [N_LINKS*FREE_W-1:0] fifo_free_i,
   input  logic [N_LINKS-1:0]        resp_done_i,
   output logic [POS_W-1:0]          lut_addr_o,
   input  logic [N_LINKS-1:0]        lut_mask_i,
   output logic [N_LINKS-1:0]        req_valid_o,
   output logic [REQ_W-1:0]          req_word_o,
   output logic                      busy_o,
   output logic                      done_o,
   output logic [N_LINKS-1:0]        tmo_flag_o
);

   // elaboration-time parameter checks
   generate
      if (N_LINKS < 1) begin : g_bad_links
         $error("N_LINKS must be at least 1");
      end
      if (N_CARDS < 1 || N_CHIPS < 1 || N_CHANS < 1) begin : g_bad_dims
         $error("index counts must be at least 1");
      end
      if (FREE_W < 1 || FREE_W > 31) begin : g_bad_free_w
         $error("FREE_W out of range");
      end
      if (FREE_MIN >= (1 << FREE_W)) begin : g_bad_free_min
         $error("FREE_MIN does not fit in FREE_W bits");
      end
      if (TMO_W < 1) begin : g_bad_tmo
         $error("TMO_W must be at least 1");
      end
   endgenerate

   seq_state_t state_q, state_d;

   logic              zs_q;
   logic [N_LINKS-1:0] req_valid_q;
   logic [REQ_W-1:0]  req_word_q;
   logic              done_q;

   logic [CARD_W-1:0] card;
   logic [CHIP_W-1:0] chip;
   logic [CHAN_W-1:0] chan;
   logic [POS_W-1:0]  pos;
   logic              last_pos;
   logic              all_room;
   logic              wait_complete, wait_expire;

   logic start_acc, mask_empty, issue, finish, adv, sweep_end, ctr_clr;

   assign start_acc  = (state_q == SEQ_IDLE) & start_i;
   assign mask_empty = (lut_mask_i == '0);
   assign issue      = (state_q == SEQ_LOOK) & ~mask_empty & all_room & ~abort_i;
   assign finish     = ((state_q == SEQ_LOOK) & mask_empty) | wait_complete | wait_expire;
   assign adv        = finish & ~last_pos & ~abort_i;
   assign sweep_end  = finish & last_pos & ~abort_i;
   assign ctr_clr    = start_acc | abort_i | sweep_end;

   lss_pos_counter #(
      .N_CARDS (N_CARDS),
      .N_CHIPS (N_CHIPS),
      .N_CHANS (N_CHANS),
      .CARD_W  (CARD_W),
      .CHIP_W  (CHIP_W),
      .CHAN_W  (CHAN_W),
      .POS_W   (POS_W)
   ) pos_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (ctr_clr),
      .adv_i  (adv),
      .card_o (card),
      .chip_o (chip),
      .chan_o (chan),
      .pos_o  (pos),
      .last_o (last_pos)
   );

   lss_space_gate #(
      .N_LINKS  (N_LINKS),
      .FREE_W   (FREE_W),
      .FREE_MIN (FREE_MIN)
   ) gate_i (
      .fifo_free_i (fifo_free_i),
      .all_room_o  (all_room)
   );

   lss_wait_tracker #(
      .N_LINKS (N_LINKS),
      .TMO_W   (TMO_W)
   ) wait_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (abort_i),
      .flag_clr_i  (start_acc),
      .load_i      (issue),
      .mask_i      (lut_mask_i),
      .tmo_limit_i (tmo_limit_i),
      .active_i    ((state_q == SEQ_WAIT) & ~abort_i),
      .resp_done_i (resp_done_i),
      .complete_o  (wait_complete),
      .expire_o    (wait_expire),
      .tmo_flag_o  (tmo_flag_o)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SEQ_IDLE: begin
            if (start_i) state_d = SEQ_LOOK;
         end
         SEQ_LOOK: begin
            if (abort_i)        state_d = SEQ_IDLE;
            else if (issue)     state_d = SEQ_WAIT;
            else if (sweep_end) state_d = SEQ_IDLE;
         end
         SEQ_WAIT: begin
            if (abort_i)        state_d = SEQ_IDLE;
            else if (sweep_end) state_d = SEQ_IDLE;
            else if (finish)    state_d = SEQ_LOOK;
         end
         default: state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= SEQ_IDLE;
         zs_q        <= 1'b0;
         req_valid_q <= '0;
         req_word_q  <= '0;
         done_q      <= 1'b0;
      end else begin
         state_q     <= state_d;
         done_q      <= sweep_end;
         req_valid_q <= issue ? lut_mask_i : '0;
         if (start_acc) begin
            zs_q <= zs_mode_i;
         end
         if (issue) begin
            req_word_q <= {zs_q, card, chip, chan};
         end
      end
   end

   assign lut_addr_o  = pos;
   assign req_valid_o = req_valid_q;
   assign req_word_o  = req_word_q;
   assign busy_o      = (state_q != SEQ_IDLE);
   assign done_o      = done_q;

endmodule

// File: rtl/lss_seq_chk.sv
module lss_seq_chk #(
   parameter int unsigned N_LINKS  = 4,
   parameter int unsigned FREE_W   = 16,
   parameter int unsigned FREE_MIN = 2048
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      start_i,
   input logic                      abort_i,
   input logic                      busy_o,
   input logic                      done_o,
   input logic [N_LINKS-1:0]        req_valid_o,
   input logic [N_LINKS-1:0]        tmo_flag_o,
   input logic [N_LINKS*FREE_W-1:0] fifo_free_i
);

   logic room_now;

   always_comb begin
      room_now = 1'b1;
      for (int l = 0; l < N_LINKS; l++) begin
         if (int'(fifo_free_i[l*FREE_W +: FREE_W]) < int'(FREE_MIN)) room_now = 1'b0;
      end
   end

   // R2
   start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && !abort_i) |=> busy_o);

   // R5
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_valid_o) |=> (req_valid_o == '0));

   // R6
   room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_valid_o) |-> $past(room_now));

   // R9
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> ((tmo_flag_o & $past(tmo_flag_o)) == $past(tmo_flag_o)));

   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R11
   abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && abort_i) |=> (!busy_o && !done_o && (req_valid_o == '0)));

   // R12
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (done_o || $past(abort_i)));

endmodule

bind link_sweep_sequencer lss_seq_chk #(
   .N_LINKS  (N_LINKS),
   .FREE_W   (FREE_W),
   .FREE_MIN (FREE_MIN)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .abort_i     (abort_i),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .req_valid_o (req_valid_o),
   .tmo_flag_o  (tmo_flag_o),
   .fifo_free_i (fifo_free_i)
);

// File: tb/link_sweep_sequencer_tb_top.sv
module link_sweep_sequencer_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int LINKS      = 4;
   localparam int CARDS      = 2;
   localparam int CHIPS      = 2;
   localparam int CHANS      = 3;
   localparam int FREE_W     = 12;
   localparam int FREE_MIN   = 2048;
   localparam int TMO_W      = 6;
   localparam int TMO        = 5;
   localparam int TOTAL      = CARDS * CHIPS * CHANS;
   localparam int CW         = (CARDS > 1) ? $clog2(CARDS) : 1;
   localparam int HW         = (CHIPS > 1) ? $clog2(CHIPS) : 1;
   localparam int NW         = (CHANS > 1) ? $clog2(CHANS) : 1;
   localparam int PW         = (TOTAL > 1) ? $clog2(TOTAL) : 1;
   localparam int RW         = 1 + CW + HW + NW;
   localparam int WD_LIMIT   = 20000;

   logic                    clk = 1'b0;
   logic                    rst_n;
   logic                    start_i, abort_i, zs_mode_i;
   logic [TMO_W-1:0]        tmo_limit_i;
   logic [LINKS*FREE_W-1:0] fifo_free_i;
   logic [LINKS-1:0]        resp_done_i;
   logic [PW-1:0]           lut_addr_o;
   logic [LINKS-1:0]        lut_mask_i;
   logic [LINKS-1:0]        req_valid_o;
   logic [RW-1:0]           req_word_o;
   logic                    busy_o, done_o;
   logic [LINKS-1:0]        tmo_flag_o;

   int checks = 0;
   int errors = 0;
   int wd     = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [LINKS-1:0] mask_fn(input int p);
      if (p % 5 == 2) return '0;
      return LINKS'(((p * 7 + 3) % 15) + 1);
   endfunction

   function automatic logic [RW-1:0] exp_word(input int p, input logic zs);
      logic [CW-1:0] c;
      logic [HW-1:0] h;
      logic [NW-1:0] n;
      c = CW'(p / (CHIPS * CHANS));
      h = HW'((p / CHANS) % CHIPS);
      n = NW'(p % CHANS);
      return {zs, c, h, n};
   endfunction

   // external position table
   always_comb lut_mask_i = mask_fn(int'(lut_addr_o));

   link_sweep_sequencer #(
      .N_LINKS  (LINKS),
      .N_CARDS  (CARDS),
      .N_CHIPS  (CHIPS),
      .N_CHANS  (CHANS),
      .FREE_W   (FREE_W),
      .FREE_MIN (FREE_MIN),
      .TMO_W    (TMO_W)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .abort_i     (abort_i),
      .zs_mode_i   (zs_mode_i),
      .tmo_limit_i (tmo_limit_i),
      .fifo_free_i (fifo_free_i),
      .resp_done_i (resp_done_i),
      .lut_addr_o  (lut_addr_o),
      .lut_mask_i  (lut_mask_i),
      .req_valid_o (req_valid_o),
      .req_word_o  (req_word_o),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .tmo_flag_o  (tmo_flag_o)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > WD_LIMIT) begin
         errors++;
         $display("FAIL R10 watchdog expired actual=%0d expected=%0d", wd, WD_LIMIT);
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   task automatic all_free();
      for (int l = 0; l < LINKS; l++) fifo_free_i[l*FREE_W +: FREE_W] = FREE_W'(FREE_MIN);
   endtask

   task automatic run_sweep(input int dly, input logic [LINKS-1:0] mute, input logic zs,
                            input int stall_at, input int restart_at);
      int cnt [LINKS];
      int exp_p, nreq, since, skipped, stall_left, trail, exp_req, base;
      logic [LINKS-1:0] prev_mask, flags_exp, rd, m;
      bit seen_done, gap_ok, restart_pend;
      for (int l = 0; l < LINKS; l++) cnt[l] = 0;
      exp_p = 0; nreq = 0; since = 0; stall_left = 0; trail = 0; exp_req = 0;
      prev_mask = '0; flags_exp = '0; seen_done = 0; gap_ok = 0; restart_pend = 0;
      for (int p = 0; p < TOTAL; p++) begin
         if (mask_fn(p) != '0) begin exp_req++; trail = 0; end
         else trail++;
      end
      zs_mode_i = zs;
      start_i   = 1'b1;
      @(negedge clk);
      start_i   = 1'b0;
      zs_mode_i = ~zs;
      check(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
      check(tmo_flag_o == '0, "R9 flags cleared by start", tmo_flag_o, 0);
      for (int cyc = 0; cyc < 3000 && !seen_done; cyc++) begin
         @(negedge clk);
         since++;
         if (restart_pend) begin start_i = 1'b0; restart_pend = 0; end
         rd = '0;
         for (int l = 0; l < LINKS; l++) begin
            if (cnt[l] > 0) begin
               cnt[l]--;
               if (cnt[l] == 0) rd[l] = 1'b1;
            end
         end
         base = (((prev_mask & mute) != '0) || dly > TMO) ? TMO + 2 : dly + 2;
         if (stall_left > 0) begin
            check(req_valid_o == '0, "R6 request while a FIFO is short", req_valid_o, 0);
            stall_left--;
            if (stall_left == 0) fifo_free_i[FREE_W +: FREE_W] = FREE_W'(FREE_MIN);
         end else if (req_valid_o != '0) begin
            skipped = 0;
            while (exp_p < TOTAL && mask_fn(exp_p) == '0) begin exp_p++; skipped++; end
            m = mask_fn(exp_p);
            check(req_valid_o == m, "R5 request mask", req_valid_o, m);
            check(req_word_o == exp_word(exp_p, zs), "R3 R4 request word", req_word_o, exp_word(exp_p, zs));
            if (nreq > 0 && gap_ok)
               check(since == base + skipped, "R7 R8 request spacing", since, base + skipped);
            gap_ok = 1;
            flags_exp = flags_exp | ((dly > TMO) ? m : (m & mute));
            for (int l = 0; l < LINKS; l++) if (m[l] && !mute[l]) cnt[l] = dly;
            prev_mask = m; nreq++; exp_p++; since = 0;
            if (nreq == stall_at) begin
               fifo_free_i[FREE_W +: FREE_W] = FREE_W'(FREE_MIN - 1);
               stall_left = 15;
               gap_ok = 0;
            end
            if (nreq == restart_at) begin start_i = 1'b1; restart_pend = 1; end
         end
         if (done_o) begin
            seen_done = 1;
            check(nreq == exp_req, "R10 request count", nreq, exp_req);
            check(tmo_flag_o == flags_exp, "R9 timeout flags", tmo_flag_o, flags_exp);
            check(busy_o == 1'b0, "R10 busy low with done", busy_o, 0);
            check(since == base - 1 + trail, "R10 done timing", since, base - 1 + trail);
         end else begin
            check(busy_o == 1'b1, "R12 busy held", busy_o, 1);
         end
         resp_done_i = rd;
      end
      start_i = 1'b0;
      check(seen_done, "R10 done seen", seen_done, 1);
      @(negedge clk);
      resp_done_i = '0;
      check(done_o == 1'b0, "R10 done one cycle", done_o, 0);
      check(busy_o == 1'b0, "R10 idle after done", busy_o, 0);
      repeat (3) @(negedge clk);
   endtask

   task automatic abort_quiet(input string tag);
      abort_i = 1'b1;
      @(negedge clk);
      abort_i = 1'b0;
      check(busy_o == 1'b0, {tag, " busy after abort"}, busy_o, 0);
      all_free();
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         check(done_o == 1'b0 && req_valid_o == '0 && busy_o == 1'b0,
               {tag, " quiet after abort"}, {done_o, req_valid_o, busy_o}, 0);
      end
   endtask

   initial begin
      rst_n = 1'b0; start_i = 1'b0; abort_i = 1'b0; zs_mode_i = 1'b0;
      tmo_limit_i = TMO_W'(TMO); resp_done_i = '0;
      all_free();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(busy_o == 1'b0, "R1 busy", busy_o, 0);
      check(done_o == 1'b0, "R1 done", done_o, 0);
      check(req_valid_o == '0, "R1 req_valid", req_valid_o, 0);
      check(tmo_flag_o == '0, "R1 flags", tmo_flag_o, 0);
      check(lut_addr_o == '0, "R1 address", lut_addr_o, 0);

      // prompt responses, stall at boundary, start while busy (R2, R6, R7)
      run_sweep(1, '0, 1'b0, 3, 5);
      // response lands in the last budget cycle: completion wins (R8)
      run_sweep(TMO, '0, 1'b1, 0, 0);
      // one cycle later: every enabled link times out (R8, R9)
      run_sweep(TMO + 1, '0, 1'b0, 0, 0);
      // one silent link (R9), flags from previous sweep cleared at start
      run_sweep(2, 4'b1000, 1'b1, 0, 0);

      // R11 abort while stalled before first request
      fifo_free_i[0 +: FREE_W] = FREE_W'(FREE_MIN - 1);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         check(req_valid_o == '0 && busy_o == 1'b1, "R6 stalled at first position",
               {req_valid_o, busy_o}, 1);
      end
      abort_quiet("R11 stall");

      // R11 abort while waiting for a response
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < 10 && req_valid_o == '0; i++) @(negedge clk);
      check(req_valid_o == mask_fn(0), "R5 first request", req_valid_o, mask_fn(0));
      abort_quiet("R11 wait");
      check(tmo_flag_o == '0, "R11 no flags after abort", tmo_flag_o, 0);

      // restart after abort begins at position 0 (R11)
      run_sweep(3, '0, 1'b0, 0, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule